// File: doc/BRIEF.md
# Register File with Link and Status Entries

This block holds the 32 general and system registers of a small load/store processor core, 32 bits each. The datapath reads two operands at once through combinational ports and writes one result per clock through a synchronous port. Alongside that ordinary path, four side-band inputs load specific entries directly:

- a call loads the call link entry;
- an exception loads the exception link entry;
- an interrupt loads the interrupt link entry;
- the ALU's flag-update path loads the status flags entry.

Entry 0 is a constant zero. Four entries are reserved for system use: the two event link entries, a system status entry and a system control entry. The write port can change them only while the supervisor-mode input is high. Sequencing of exceptions and interrupts sits outside this block. Each strobe is a single-cycle pulse that comes with the return address or the flag value it stores.

Top module: `sysreg_file`

## Requirements
- R1: Each read port returns the current content of the entry its 5-bit address selects, combinationally, so the output follows an address change without any clock edge.
- R2: Entry 0 always reads as zero, and any write-port write to entry 0 is discarded.
- R3: With `wr_en` high, a write to an unguarded entry (1 to 16, 20, and 23 to 31) stores `wr_data` at the next rising edge of `clk`.
- R4: A read of an entry in the same cycle as a write to it returns the value held before the write. No write-through bypass exists.
- R5: Entry 17 (call link) loads `call_ret_addr` on the edge where `call_stb` is high. A write-port write to entry 17 has no effect.
- R6: `exc_stb` loads `exc_ret_addr` into entry 18, and `irq_stb` loads `irq_ret_addr` into entry 19. Both work whatever the level of `priv_mode`.
- R7: Write-port writes to the guarded entries 18, 19, 21 and 22 take effect only while `priv_mode` is high. Otherwise they are discarded.
- R8: `flag_upd_en` loads entry 20 with the 4-bit `flag_upd_val` in bits 3:0 and zeros in bits 31:4. The bit order is zero flag in bit 0, overflow in bit 1, sign in bit 2 and carry in bit 3.
- R9: When a side-band update and a write-port write hit the same entry on one edge, the side-band value is the one stored.
- R10: While `rst` is high at a rising edge, every entry clears to zero, and this takes priority over all writes and updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_addr_a | input | 5 | Read port A entry select |
| rd_data_a | output | 32 | Read port A data |
| rd_addr_b | input | 5 | Read port B entry select |
| rd_data_b | output | 32 | Read port B data |
| wr_en | input | 1 | Write-port enable |
| wr_addr | input | 5 | Write-port entry select |
| wr_data | input | 32 | Write-port data |
| priv_mode | input | 1 | Supervisor mode; unlocks guarded entries for the write port |
| call_stb | input | 1 | Call event: load call link entry |
| call_ret_addr | input | 32 | Return address for a call |
| exc_stb | input | 1 | Exception event: load exception link entry |
| exc_ret_addr | input | 32 | Return address for an exception |
| irq_stb | input | 1 | Interrupt event: load interrupt link entry |
| irq_ret_addr | input | 32 | Return address for an interrupt |
| flag_upd_en | input | 1 | ALU flag update strobe |
| flag_upd_val | input | 4 | New flag bits {carry, sign, overflow, zero} |

## Verification
The hardest case to produce is a write-port write and a side-band strobe that hit the same guarded entry on the same edge while `priv_mode` is high. Only that combination shows whether the event really wins, rather than being masked by the privilege block. Random stimulus reaches it seldom, so directed steps set up a privileged write to entry 19 together with `irq_stb`, and a write to entry 20 together with `flag_upd_en`. Random cycles bias one read address toward the current write address, so that same-cycle read-before-write is hit often across every entry class.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

   // Role of each register-file entry; decides which sources may write it.
   typedef enum logic [2:0] {
      EK_ZERO,
      EK_PLAIN,
      EK_CALL_LINK,
      EK_EXC_LINK,
      EK_IRQ_LINK,
      EK_FLAGS,
      EK_GUARDED
   } entry_kind_e;

   localparam int IDX_CALL_LINK = 17;
   localparam int IDX_EXC_LINK  = 18;
   localparam int IDX_IRQ_LINK  = 19;
   localparam int IDX_FLAGS     = 20;
   localparam int IDX_SYS_STAT  = 21;
   localparam int IDX_SYS_CTRL  = 22;
   localparam int MIN_ENTRIES   = 23;

   function automatic entry_kind_e kind_of(input int idx);
      entry_kind_e k;
      case (idx)
         0:             k = EK_ZERO;
         IDX_CALL_LINK: k = EK_CALL_LINK;
         IDX_EXC_LINK:  k = EK_EXC_LINK;
         IDX_IRQ_LINK:  k = EK_IRQ_LINK;
         IDX_FLAGS:     k = EK_FLAGS;
         IDX_SYS_STAT,
         IDX_SYS_CTRL:  k = EK_GUARDED;
         default:       k = EK_PLAIN;
      endcase
      return k;
   endfunction

   // Entries whose write-port access needs supervisor mode.
   function automatic logic needs_priv(input entry_kind_e k);
      return (k == EK_EXC_LINK) || (k == EK_IRQ_LINK) || (k == EK_GUARDED);
   endfunction

endpackage

// File: rtl/sysreg_wrdec.sv
module sysreg_wrdec
   import sysreg_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 5,
   parameter int FLAG_W    = 4,
   parameter int N_ENTRIES = 32
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              priv_mode,
   input  logic              call_stb,
   input  logic [DATA_W-1:0] call_ret_addr,
   input  logic              exc_stb,
   input  logic [DATA_W-1:0] exc_ret_addr,
   input  logic              irq_stb,
   input  logic [DATA_W-1:0] irq_ret_addr,
   input  logic              flag_upd_en,
   input  logic [FLAG_W-1:0] flag_upd_val,
   output logic              ent_we [N_ENTRIES],
   output logic [DATA_W-1:0] ent_wd [N_ENTRIES]
);

   localparam int PAD_W = DATA_W - FLAG_W;

   logic [DATA_W-1:0] flag_word;
   assign flag_word = {{PAD_W{1'b0}}, flag_upd_val};

   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
      localparam entry_kind_e KIND = kind_of(i);
      logic addr_hit;
      logic port_ok;
      logic evt_hit;
      logic [DATA_W-1:0] evt_data;

      assign addr_hit = wr_en && (wr_addr == ADDR_W'(i));

      if (KIND == EK_ZERO || KIND == EK_CALL_LINK) begin : g_port_off
         assign port_ok = 1'b0;
      end else if (needs_priv(KIND)) begin : g_port_priv
         assign port_ok = addr_hit && priv_mode;
      end else begin : g_port_open
         assign port_ok = addr_hit;
      end

      if (KIND == EK_CALL_LINK) begin : g_evt_call
         assign evt_hit  = call_stb;
         assign evt_data = call_ret_addr;
      end else if (KIND == EK_EXC_LINK) begin : g_evt_exc
         assign evt_hit  = exc_stb;
         assign evt_data = exc_ret_addr;
      end else if (KIND == EK_IRQ_LINK) begin : g_evt_irq
         assign evt_hit  = irq_stb;
         assign evt_data = irq_ret_addr;
      end else if (KIND == EK_FLAGS) begin : g_evt_flags
         assign evt_hit  = flag_upd_en;
         assign evt_data = flag_word;
      end else begin : g_evt_none
         assign evt_hit  = 1'b0;
         assign evt_data = '0;
      end

      // Side-band event has priority over the write port.
      assign ent_we[i] = evt_hit || port_ok;
      assign ent_wd[i] = evt_hit ? evt_data : wr_data;
   end

endmodule

// File: rtl/sysreg_store.sv
module sysreg_store #(
   parameter int DATA_W    = 32,
   parameter int N_ENTRIES = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ent_we [N_ENTRIES],
   input  logic [DATA_W-1:0] ent_wd [N_ENTRIES],
   output logic [DATA_W-1:0] ent_q  [N_ENTRIES]
);

   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cell
      always_ff @(posedge clk) begin
         if (rst) begin
            ent_q[i] <= '0;
         end else if (ent_we[i]) begin
            ent_q[i] <= ent_wd[i];
         end
      end
   end

endmodule

// File: rtl/sysreg_rdport.sv
module sysreg_rdport #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 5,
   parameter int N_ENTRIES = 32
) (
   input  logic [DATA_W-1:0] ent_q [N_ENTRIES],
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   always_comb begin
      if (rd_addr == '0) begin
         rd_data = '0;
      end else begin
         rd_data = ent_q[rd_addr];
      end
   end

endmodule

// File: rtl/sysreg_file.sv
module sysreg_file
   import sysreg_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 5,
   parameter int FLAG_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] rd_addr_a,
   output logic [DATA_W-1:0] rd_data_a,
   input  logic [ADDR_W-1:0] rd_addr_b,
   output logic [DATA_W-1:0] rd_data_b,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              priv_mode,
   input  logic              call_stb,
   input  logic [DATA_W-1:0] call_ret_addr,
   input  logic              exc_stb,
   input  logic [DATA_W-1:0] exc_ret_addr,
   input  logic              irq_stb,
   input  logic [DATA_W-1:0] irq_ret_addr,
   input  logic              flag_upd_en,
   input  logic [FLAG_W-1:0] flag_upd_val
);

   localparam int N_ENTRIES = 1 << ADDR_W;

   if (N_ENTRIES < MIN_ENTRIES) begin : g_chk_depth
      $error("sysreg_file: ADDR_W too small for the fixed system entries");
   end
   if (FLAG_W < 1 || FLAG_W >= DATA_W) begin : g_chk_flags
      $error("sysreg_file: FLAG_W must lie between 1 and DATA_W-1");
   end

   logic              ent_we [N_ENTRIES];
   logic [DATA_W-1:0] ent_wd [N_ENTRIES];
   logic [DATA_W-1:0] regs_q [N_ENTRIES];

   sysreg_wrdec #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLAG_W(FLAG_W), .N_ENTRIES(N_ENTRIES)
   ) i_wrdec (
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .priv_mode(priv_mode),
      .call_stb(call_stb), .call_ret_addr(call_ret_addr),
      .exc_stb(exc_stb), .exc_ret_addr(exc_ret_addr),
      .irq_stb(irq_stb), .irq_ret_addr(irq_ret_addr),
      .flag_upd_en(flag_upd_en), .flag_upd_val(flag_upd_val),
      .ent_we(ent_we), .ent_wd(ent_wd)
   );

   sysreg_store #(
      .DATA_W(DATA_W), .N_ENTRIES(N_ENTRIES)
   ) i_store (
      .clk(clk), .rst(rst), .ent_we(ent_we), .ent_wd(ent_wd), .ent_q(regs_q)
   );

   sysreg_rdport #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_ENTRIES(N_ENTRIES)
   ) i_rd_a (
      .ent_q(regs_q), .rd_addr(rd_addr_a), .rd_data(rd_data_a)
   );

   sysreg_rdport #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_ENTRIES(N_ENTRIES)
   ) i_rd_b (
      .ent_q(regs_q), .rd_addr(rd_addr_b), .rd_data(rd_data_b)
   );

endmodule

// File: rtl/sysreg_file_chk.sv
module sysreg_file_chk
   import sysreg_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 5,
   parameter int FLAG_W    = 4,
   parameter int N_ENTRIES = 32
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] rd_addr_a,
   input logic [DATA_W-1:0] rd_data_a,
   input logic [DATA_W-1:0] rd_data_b,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              priv_mode,
   input logic              call_stb,
   input logic [DATA_W-1:0] call_ret_addr,
   input logic              exc_stb,
   input logic [DATA_W-1:0] exc_ret_addr,
   input logic              irq_stb,
   input logic [DATA_W-1:0] irq_ret_addr,
   input logic              flag_upd_en,
   input logic [FLAG_W-1:0] flag_upd_val,
   input logic [DATA_W-1:0] regs_q [N_ENTRIES]
);

   localparam int PAD_W = DATA_W - FLAG_W;

   // R2: entry 0 reads as zero
   a_r2_zero_read: assert property (@(posedge clk) disable iff (rst)
      (rd_addr_a == '0) |-> (rd_data_a == '0));

   // R5: call strobe loads the call link entry
   a_r5_call_load: assert property (@(posedge clk) disable iff (rst)
      call_stb |=> (regs_q[IDX_CALL_LINK] == $past(call_ret_addr)));

   // R5: without a call strobe the call link entry holds
   a_r5_call_only: assert property (@(posedge clk) disable iff (rst)
      !call_stb |=> $stable(regs_q[IDX_CALL_LINK]));

   // R6 / R9: exception and interrupt strobes load their link entries
   a_r6_exc_load: assert property (@(posedge clk) disable iff (rst)
      exc_stb |=> (regs_q[IDX_EXC_LINK] == $past(exc_ret_addr)));

   a_r6_irq_load: assert property (@(posedge clk) disable iff (rst)
      irq_stb |=> (regs_q[IDX_IRQ_LINK] == $past(irq_ret_addr)));

   // R7: guarded write without supervisor mode is dropped
   a_r7_guard_block: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !priv_mode &&
       (wr_addr == ADDR_W'(IDX_SYS_STAT) || wr_addr == ADDR_W'(IDX_SYS_CTRL)))
      |=> (regs_q[$past(wr_addr)] == $past(regs_q[wr_addr])));

   // R8 / R9: flag update loads the flags entry
   a_r8_flag_load: assert property (@(posedge clk) disable iff (rst)
      flag_upd_en |=> (regs_q[IDX_FLAGS] == {{PAD_W{1'b0}}, $past(flag_upd_val)}));

   // R10: after a reset edge every read returns zero
   a_r10_reset_clear: assert property (@(posedge clk)
      rst |=> (rd_data_a == '0 && rd_data_b == '0));

endmodule

bind sysreg_file sysreg_file_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLAG_W(FLAG_W), .N_ENTRIES(N_ENTRIES)
) i_sysreg_file_chk (
   .clk(clk), .rst(rst), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
   .rd_data_b(rd_data_b), .wr_en(wr_en), .wr_addr(wr_addr), .priv_mode(priv_mode),
   .call_stb(call_stb), .call_ret_addr(call_ret_addr),
   .exc_stb(exc_stb), .exc_ret_addr(exc_ret_addr),
   .irq_stb(irq_stb), .irq_ret_addr(irq_ret_addr),
   .flag_upd_en(flag_upd_en), .flag_upd_val(flag_upd_val), .regs_q(regs_q)
);

// File: tb/test_sysreg_file.sv
module test_sysreg_file;

   logic        clk = 1'b0;
   logic        rst;
   logic [4:0]  rd_addr_a, rd_addr_b, wr_addr;
   logic [31:0] rd_data_a, rd_data_b, wr_data;
   logic        wr_en, priv_mode, call_stb, exc_stb, irq_stb, flag_upd_en;
   logic [31:0] call_ret_addr, exc_ret_addr, irq_ret_addr;
   logic [3:0]  flag_upd_val;

   logic [31:0] model [32];
   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   sysreg_file i_sysreg_file (
      .clk(clk), .rst(rst),
      .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
      .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .priv_mode(priv_mode),
      .call_stb(call_stb), .call_ret_addr(call_ret_addr),
      .exc_stb(exc_stb), .exc_ret_addr(exc_ret_addr),
      .irq_stb(irq_stb), .irq_ret_addr(irq_ret_addr),
      .flag_upd_en(flag_upd_en), .flag_upd_val(flag_upd_val)
   );

   function automatic string kind_tag(input logic [4:0] a);
      case (a)
         5'd0:               return "R2";
         5'd17:              return "R5";
         5'd18, 5'd19:       return "R6";
         5'd20:              return "R8";
         5'd21, 5'd22:       return "R7";
         default:            return "R3";
      endcase
   endfunction

   function automatic bit guarded(input logic [4:0] a);
      return (a == 5'd18) || (a == 5'd19) || (a == 5'd21) || (a == 5'd22);
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle();
      rst = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; priv_mode = 1'b0;
      call_stb = 1'b0; exc_stb = 1'b0; irq_stb = 1'b0; flag_upd_en = 1'b0;
      call_ret_addr = '0; exc_ret_addr = '0; irq_ret_addr = '0; flag_upd_val = '0;
   endtask

   function automatic string pick(input string tag, input logic [4:0] a);
      if (tag != "") return tag;
      if (!rst && wr_en && a == wr_addr && a != 5'd0) return "R4";
      return kind_tag(a);
   endfunction

   // Check both reads against the pre-edge model, then advance one clock.
   task automatic tick(input string tag);
      logic [31:0] nxt [32];
      #1;
      chk(rd_data_a, model[rd_addr_a], pick(tag, rd_addr_a));
      chk(rd_data_b, model[rd_addr_b], pick(tag, rd_addr_b));
      nxt = model;
      if (rst) begin
         for (int k = 0; k < 32; k++) nxt[k] = '0;
      end else begin
         if (wr_en && wr_addr != 5'd0 && wr_addr != 5'd17 &&
             (!guarded(wr_addr) || priv_mode))
            nxt[wr_addr] = wr_data;
         if (call_stb)    nxt[17] = call_ret_addr;
         if (exc_stb)     nxt[18] = exc_ret_addr;
         if (irq_stb)     nxt[19] = irq_ret_addr;
         if (flag_upd_en) nxt[20] = {28'd0, flag_upd_val};
      end
      @(posedge clk);
      model = nxt;
      @(negedge clk);
   endtask

   task automatic show(input logic [4:0] a, input logic [4:0] b, input string tag);
      idle();
      rd_addr_a = a; rd_addr_b = b;
      tick(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      idle();
      rd_addr_a = '0; rd_addr_b = '0;
      rst = 1'b1;
      @(negedge clk); @(negedge clk);
      for (int k = 0; k < 32; k++) model[k] = '0;

      // R10: every entry zero after reset
      for (int k = 0; k < 16; k++) show(5'(k), 5'(31 - k), "R10");

      // R2: write to entry 0 is discarded
      idle(); wr_en = 1'b1; wr_addr = 5'd0; wr_data = 32'hdead_beef; tick("R2");
      show(5'd0, 5'd0, "R2");

      // R3 / R4: write entry 5 while reading it; old value seen first
      idle(); wr_en = 1'b1; wr_addr = 5'd5; wr_data = 32'h1234_5678;
      rd_addr_a = 5'd5; rd_addr_b = 5'd5; tick("R4");
      show(5'd5, 5'd20, "R3");

      // R1: combinational read follows address with no edge
      rd_addr_a = 5'd0; #1; chk(rd_data_a, 32'd0, "R1");
      rd_addr_a = 5'd5; #1; chk(rd_data_a, 32'h1234_5678, "R1");
      @(negedge clk);

      // R5: write port cannot touch entry 17; call strobe can
      idle(); wr_en = 1'b1; wr_addr = 5'd17; wr_data = 32'haaaa_5555; priv_mode = 1'b1; tick("");
      show(5'd17, 5'd17, "R5");
      idle(); call_stb = 1'b1; call_ret_addr = 32'h0000_1f40; tick("");
      show(5'd17, 5'd0, "R5");

      // R7: guarded entry blocked in user mode, accepted in supervisor mode
      idle(); wr_en = 1'b1; wr_addr = 5'd21; wr_data = 32'hcafe_0001; tick("");
      show(5'd21, 5'd22, "R7");
      idle(); wr_en = 1'b1; wr_addr = 5'd22; wr_data = 32'hcafe_0002; priv_mode = 1'b1; tick("");
      show(5'd22, 5'd21, "R7");
      idle(); wr_en = 1'b1; wr_addr = 5'd18; wr_data = 32'h0bad_0bad; tick("");
      show(5'd18, 5'd18, "R7");

      // R6: exception strobe works in user mode
      idle(); exc_stb = 1'b1; exc_ret_addr = 32'h8000_0100; tick("");
      show(5'd18, 5'd19, "R6");

      // R9: privileged write and interrupt to entry 19 together
      idle(); wr_en = 1'b1; wr_addr = 5'd19; wr_data = 32'h1111_2222; priv_mode = 1'b1;
      irq_stb = 1'b1; irq_ret_addr = 32'h4000_0044; tick("");
      show(5'd19, 5'd19, "R9");

      // R8 / R3: ordinary write to flags entry, then flag update
      idle(); wr_en = 1'b1; wr_addr = 5'd20; wr_data = 32'hffff_fff0; tick("");
      show(5'd20, 5'd20, "R3");
      idle(); flag_upd_en = 1'b1; flag_upd_val = 4'b1010; tick("");
      show(5'd20, 5'd0, "R8");

      // R9: flag update beats a same-cycle write to entry 20
      idle(); wr_en = 1'b1; wr_addr = 5'd20; wr_data = 32'h7777_7777;
      flag_upd_en = 1'b1; flag_upd_val = 4'b0101; tick("");
      show(5'd20, 5'd20, "R9");

      // R10: reset wins over a write in the same cycle
      idle(); rst = 1'b1; wr_en = 1'b1; wr_addr = 5'd9; wr_data = 32'h9999_9999; tick("");
      show(5'd9, 5'd17, "R10");

      // Random traffic checked against the model
      for (int n = 0; n < 4000; n++) begin
         idle();
         wr_en        = 1'($urandom_range(0, 1));
         wr_addr      = 5'($urandom);
         wr_data      = $urandom;
         priv_mode    = 1'($urandom_range(0, 1));
         call_stb     = ($urandom_range(0, 7) == 0);
         call_ret_addr = $urandom;
         exc_stb      = ($urandom_range(0, 9) == 0);
         exc_ret_addr = $urandom;
         irq_stb      = ($urandom_range(0, 9) == 0);
         irq_ret_addr = $urandom;
         flag_upd_en  = ($urandom_range(0, 5) == 0);
         flag_upd_val = 4'($urandom);
         rst          = ($urandom_range(0, 299) == 0);
         rd_addr_a    = ($urandom_range(0, 2) == 0) ? wr_addr : 5'($urandom);
         rd_addr_b    = 5'($urandom);
         tick("");
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule